// File: doc/BRIEF.md
# Nested Trap State Stack

This block handles entry to and return from traps in a processor that allows traps to nest. When a trap is accepted, the block saves the caller's context into a storage slot selected by the current trap level. That context is the condition codes, the address-space identifier, the masked processor state, the window pointer, the PC, the next PC and the trap type. The block then computes the handler address from the trap base and the trap type, forces the processor-state bits that trap entry requires, adjusts the window pointer for window-management traps and raises the trap level.

Two return commands restore the saved context from the level below and lower the trap level. "Done" resumes at the instruction after the trapped one. "Retry" re-executes the trapped instruction. The core keeps its own architectural registers: it presents the current values on the `cur_*` inputs and loads the `new_*` outputs in the cycle in which `upd_valid` is high.

Near the top of the stack the block enters a reduced-state mode. A trap that arrives when every level is already in use is refused, and the block reports it on an error strobe.

Top module: `trap_state_stack`

## Requirements
- R1: After reset, `tl` is 0 and `upd_valid`, `trap_err`, `top_tt` and `top_state` are all 0.
- R2: An accepted trap saves a state word at the current level. The word holds the condition codes in bits 39:32, the address-space identifier in bits 31:24, `cur_pstate & 0xf3f` in bits 19:8 and the zero-extended window pointer in bits 7:0. All other bits are 0. A later return restores `new_ccr`, `new_asi`, `new_pstate` and `new_cwp` from that word.
- R3: On an accepted trap, `new_ccr` and `new_asi` equal the current values. `new_pstate` equals `(cur_pstate & 0xf3f)` with bit 4 (FP enable), bit 2 (privileged) and bit 0 (alternate globals) set.
- R4: On an accepted trap, `new_pc` is built as follows: bits AW-1:15 come from `tba_hi`; bit 14 is 1 when the level before the trap was above 1; bits 13:5 hold the trap type; bits 4:0 are 0. `new_npc` equals `new_pc + 4`.
- R5: A trap accepted below level MAXTL-1 raises `tl` by one and leaves pstate bit 5 (reduced state) as it was in `cur_pstate`. A trap accepted at level MAXTL-1 raises `tl` to MAXTL and sets pstate bit 5.
- R6: A trap that arrives at level MAXTL pulses `trap_err` for one cycle. In that case `upd_valid` stays low and neither the level nor any saved slot changes.
- R7: Done lowers `tl` by one. It sets `new_pc` to the saved next PC and `new_npc` to the saved next PC + 4.
- R8: Retry lowers `tl` by one. It sets `new_pc` to the saved PC and `new_npc` to the saved next PC.
- R9: For trap type 0x024, `new_cwp = cur_cwp - 1`. For types whose bits 8:6 are 010, `new_cwp = cur_cwp - cur_cansave - 2`. For types whose bits 8:6 are 011, `new_cwp = cur_cwp + 1`. Any other type leaves the window pointer unchanged. All results wrap modulo NWIN.
- R10: A trap request takes priority over a return in the same cycle, and done takes priority over retry. A return at level 0 is ignored: `upd_valid` stays low and `tl` stays 0.
- R11: `top_tt` and `top_state` show the trap type and the state word of slot `tl-1`. Both read 0 when `tl` is 0.
- R12: `upd_valid` and `trap_err` are single-cycle strobes in the cycle after the command, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request |
| trap_type | input | 9 | Trap type |
| done_req | input | 1 | Return, resume after the trapped instruction |
| retry_req | input | 1 | Return, re-execute the trapped instruction |
| tba_hi | input | AW-15 | Trap base, upper bits |
| cur_pc | input | AW | Current PC |
| cur_npc | input | AW | Current next PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | log2(NWIN) | Current window pointer |
| cur_cansave | input | log2(NWIN) | Windows that can be saved |
| upd_valid | output | 1 | The `new_*` outputs are valid this cycle |
| new_pc | output | AW | PC to load |
| new_npc | output | AW | Next PC to load |
| new_ccr | output | 8 | Condition codes to load |
| new_asi | output | 8 | Address-space identifier to load |
| new_pstate | output | 12 | Processor state to load |
| new_cwp | output | log2(NWIN) | Window pointer to load |
| trap_err | output | 1 | Trap refused: the stack was already full |
| tl | output | log2(MAXTL+1) | Current trap level |
| top_tt | output | 9 | Trap type at the top of the stack |
| top_state | output | 40 | Saved state word at the top of the stack |

## Verification
Two functions can collide in one cycle: a trap and a return, and also the two returns with each other. The bench raises `trap_req` together with `done_req`, once with the stack full and once part way down. It also raises `done_req` together with `retry_req`. A reference stack kept in the bench predicts the level, the strobes and the restored PC pair for each case. For a trap colliding with a return, the expected result is the refused-trap strobe or the trap's vector. For the two returns colliding, the expected result is done's resume address, not retry's.

// File: rtl/tss_pkg.sv
package tss_pkg;

  localparam int CCR_W   = 8;
  localparam int ASI_W   = 8;
  localparam int PST_W   = 12;
  localparam int TT_W    = 9;
  localparam int WORD_W  = 40;
  localparam int CWP_FLD = 8;

  localparam logic [PST_W-1:0] PST_KEEP = 12'hf3f;
  localparam logic [PST_W-1:0] PST_FPEN = 12'h010;
  localparam logic [PST_W-1:0] PST_PRIV = 12'h004;
  localparam logic [PST_W-1:0] PST_ALTG = 12'h001;
  localparam logic [PST_W-1:0] PST_RSTM = 12'h020;

  localparam logic [TT_W-1:0] TT_CLEANWIN  = 9'h024;
  localparam logic [2:0]      TT_GRP_SPILL = 3'b010;
  localparam logic [2:0]      TT_GRP_FILL  = 3'b011;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_ENTER,
    CMD_DONE,
    CMD_RETRY,
    CMD_REFUSE
  } tss_cmd_e;

  // Layout: ccr 39:32, asi 31:24, pad 23:20, pstate 19:8, cwp 7:0
  function automatic logic [WORD_W-1:0] pack_word(
    input logic [CCR_W-1:0]   ccr,
    input logic [ASI_W-1:0]   asi,
    input logic [PST_W-1:0]   pst,
    input logic [CWP_FLD-1:0] cwp8
  );
    return {ccr, asi, 4'h0, pst & PST_KEEP, cwp8};
  endfunction

endpackage

// File: rtl/tss_level_ctrl.sv
module tss_level_ctrl
  import tss_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TLW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trap_req,
  input  logic           done_req,
  input  logic           retry_req,
  output tss_cmd_e       cmd,
  output logic [TLW-1:0] tl_q,
  output logic           red_entry,
  output logic           nested
);

  localparam logic [TLW-1:0] TL_FULL = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_LAST = TLW'(MAXTL - 1);
  localparam logic [TLW-1:0] TL_ONE  = TLW'(1);

  logic           full, empty, tl_en;
  logic [TLW-1:0] tl_d;

  assign full      = (tl_q == TL_FULL);
  assign empty     = (tl_q == '0);
  assign red_entry = (tl_q >= TL_LAST);
  assign nested    = (tl_q > TL_ONE);

  always_comb begin
    cmd   = CMD_IDLE;
    tl_d  = tl_q;
    tl_en = 1'b0;
    if (trap_req) begin
      if (full) begin
        cmd = CMD_REFUSE;
      end else begin
        cmd   = CMD_ENTER;
        tl_d  = tl_q + TL_ONE;
        tl_en = 1'b1;
      end
    end else if (done_req && !empty) begin
      cmd   = CMD_DONE;
      tl_d  = tl_q - TL_ONE;
      tl_en = 1'b1;
    end else if (retry_req && !empty) begin
      cmd   = CMD_RETRY;
      tl_d  = tl_q - TL_ONE;
      tl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q <= '0;
    end else if (tl_en) begin
      tl_q <= tl_d;
    end
  end

endmodule

// File: rtl/tss_frame_store.sv
module tss_frame_store
  import tss_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TLW   = 3,
  parameter int AW    = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [TLW-1:0]    wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     wr_pc,
  input  logic [AW-1:0]     wr_npc,
  input  logic [TT_W-1:0]   wr_tt,
  input  logic [TLW-1:0]    rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     rd_pc,
  output logic [AW-1:0]     rd_npc,
  output logic [TT_W-1:0]   rd_tt
);

  logic [WORD_W-1:0] word_a [DEPTH];
  logic [AW-1:0]     pc_a   [DEPTH];
  logic [AW-1:0]     npc_a  [DEPTH];
  logic [TT_W-1:0]   tt_a   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    logic [AW-1:0]     pc_q, npc_q;
    logic [TT_W-1:0]   tt_q;
    logic              slot_we;

    assign slot_we = wr_en && (wr_idx == TLW'(g));

    always_ff @(posedge clk) begin
      if (slot_we) begin
        word_q <= wr_word;
        pc_q   <= wr_pc;
        npc_q  <= wr_npc;
        tt_q   <= wr_tt;
      end
    end

    assign word_a[g] = word_q;
    assign pc_a[g]   = pc_q;
    assign npc_a[g]  = npc_q;
    assign tt_a[g]   = tt_q;
  end

  always_comb begin
    rd_word = '0;
    rd_pc   = '0;
    rd_npc  = '0;
    rd_tt   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == TLW'(i)) begin
        rd_word = word_a[i];
        rd_pc   = pc_a[i];
        rd_npc  = npc_a[i];
        rd_tt   = tt_a[i];
      end
    end
  end

endmodule

// File: rtl/tss_vector_gen.sv
module tss_vector_gen
  import tss_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CWPW = 3
) (
  input  logic [TT_W-1:0] trap_type,
  input  logic [AW-16:0]  tba_hi,
  input  logic            nested,
  input  logic [CWPW-1:0] cwp,
  input  logic [CWPW-1:0] cansave,
  output logic [AW-1:0]   vec_pc,
  output logic [CWPW-1:0] cwp_adj
);

  localparam logic [CWPW-1:0] ONE = CWPW'(1);
  localparam logic [CWPW-1:0] TWO = CWPW'(2);

  assign vec_pc = {tba_hi, nested, trap_type, 5'b0_0000};

  always_comb begin
    cwp_adj = cwp;
    if (trap_type == TT_CLEANWIN) begin
      cwp_adj = cwp - ONE;
    end else if (trap_type[8:6] == TT_GRP_SPILL) begin
      cwp_adj = cwp - cansave - TWO;
    end else if (trap_type[8:6] == TT_GRP_FILL) begin
      cwp_adj = cwp + ONE;
    end
  end

endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
  import tss_pkg::*;
#(
  parameter  int MAXTL = 5,
  parameter  int NWIN  = 8,
  parameter  int AW    = 32,
  localparam int TLW   = $clog2(MAXTL + 1),
  localparam int CWPW  = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [TT_W-1:0]   trap_type,
  input  logic              done_req,
  input  logic              retry_req,
  input  logic [AW-16:0]    tba_hi,
  input  logic [AW-1:0]     cur_pc,
  input  logic [AW-1:0]     cur_npc,
  input  logic [CCR_W-1:0]  cur_ccr,
  input  logic [ASI_W-1:0]  cur_asi,
  input  logic [PST_W-1:0]  cur_pstate,
  input  logic [CWPW-1:0]   cur_cwp,
  input  logic [CWPW-1:0]   cur_cansave,
  output logic              upd_valid,
  output logic [AW-1:0]     new_pc,
  output logic [AW-1:0]     new_npc,
  output logic [CCR_W-1:0]  new_ccr,
  output logic [ASI_W-1:0]  new_asi,
  output logic [PST_W-1:0]  new_pstate,
  output logic [CWPW-1:0]   new_cwp,
  output logic              trap_err,
  output logic [TLW-1:0]    tl,
  output logic [TT_W-1:0]   top_tt,
  output logic [WORD_W-1:0] top_state
);

  localparam logic [AW-1:0] STEP = AW'(4);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tss_cmd_e          cmd;
  logic              red_entry, nested;
  logic [AW-1:0]     vec_pc;
  logic [CWPW-1:0]   cwp_adj;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [AW-1:0]     rd_pc, rd_npc;
  logic [TT_W-1:0]   rd_tt;
  logic [TLW-1:0]    rd_idx;

  tss_level_ctrl #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trap_req  (trap_req),
    .done_req  (done_req),
    .retry_req (retry_req),
    .cmd       (cmd),
    .tl_q      (tl),
    .red_entry (red_entry),
    .nested    (nested)
  );

  tss_vector_gen #(.AW(AW), .CWPW(CWPW)) u_vec (
    .trap_type (trap_type),
    .tba_hi    (tba_hi),
    .nested    (nested),
    .cwp       (cur_cwp),
    .cansave   (cur_cansave),
    .vec_pc    (vec_pc),
    .cwp_adj   (cwp_adj)
  );

  assign wr_word = pack_word(cur_ccr, cur_asi, cur_pstate,
                             {{(CWP_FLD-CWPW){1'b0}}, cur_cwp});
  assign rd_idx  = tl - TLW'(1);

  tss_frame_store #(.DEPTH(MAXTL), .TLW(TLW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (cmd == CMD_ENTER),
    .wr_idx  (tl),
    .wr_word (wr_word),
    .wr_pc   (cur_pc),
    .wr_npc  (cur_npc),
    .wr_tt   (trap_type),
    .rd_idx  (rd_idx),
    .rd_word (rd_word),
    .rd_pc   (rd_pc),
    .rd_npc  (rd_npc),
    .rd_tt   (rd_tt)
  );

  assign top_tt    = (tl == '0) ? '0 : rd_tt;
  assign top_state = (tl == '0) ? '0 : rd_word;

  // next-state
  logic              upd_d, err_d;
  logic [AW-1:0]     pc_d, npc_d;
  logic [CCR_W-1:0]  ccr_d;
  logic [ASI_W-1:0]  asi_d;
  logic [PST_W-1:0]  pst_d;
  logic [CWPW-1:0]   cwp_d;

  always_comb begin
    upd_d = 1'b0;
    err_d = 1'b0;
    pc_d  = new_pc;
    npc_d = new_npc;
    ccr_d = new_ccr;
    asi_d = new_asi;
    pst_d = new_pstate;
    cwp_d = new_cwp;
    unique case (cmd)
      CMD_ENTER: begin
        upd_d = 1'b1;
        pc_d  = vec_pc;
        npc_d = vec_pc + STEP;
        ccr_d = cur_ccr;
        asi_d = cur_asi;
        pst_d = (cur_pstate & PST_KEEP) | PST_FPEN | PST_PRIV | PST_ALTG
              | (red_entry ? PST_RSTM : '0);
        cwp_d = cwp_adj;
      end
      CMD_DONE, CMD_RETRY: begin
        upd_d = 1'b1;
        pc_d  = (cmd == CMD_DONE) ? rd_npc : rd_pc;
        npc_d = (cmd == CMD_DONE) ? rd_npc + STEP : rd_npc;
        ccr_d = rd_word[39:32];
        asi_d = rd_word[31:24];
        pst_d = rd_word[19:8];
        cwp_d = rd_word[CWPW-1:0];
      end
      CMD_REFUSE: err_d = 1'b1;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upd_valid  <= 1'b0;
      trap_err   <= 1'b0;
      new_pc     <= '0;
      new_npc    <= '0;
      new_ccr    <= '0;
      new_asi    <= '0;
      new_pstate <= '0;
      new_cwp    <= '0;
    end else begin
      upd_valid <= upd_d;
      trap_err  <= err_d;
      if (upd_d) begin
        new_pc     <= pc_d;
        new_npc    <= npc_d;
        new_ccr    <= ccr_d;
        new_asi    <= asi_d;
        new_pstate <= pst_d;
        new_cwp    <= cwp_d;
      end
    end
  end

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int MAXTL = 5,
  parameter int TLW   = 3,
  parameter int AW    = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trap_req,
  input logic           done_req,
  input logic           retry_req,
  input logic [TLW-1:0] tl,
  input logic           upd_valid,
  input logic           trap_err,
  input logic [AW-1:0]  new_pc,
  input logic [AW-1:0]  new_npc,
  input logic [11:0]    new_pstate
);

  localparam logic [TLW-1:0] TL_FULL = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_LAST = TLW'(MAXTL - 1);

  p_level_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl < TL_FULL |=> tl == $past(tl) + TLW'(1));

  p_red_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl == TL_LAST |=> new_pstate[5]);

  p_entry_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl < TL_FULL |=> new_pstate[4] && new_pstate[2] && new_pstate[0]);

  p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl < TL_FULL |=> upd_valid && new_npc == new_pc + AW'(4)
                                 && new_pc[4:0] == 5'd0);

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && tl == TL_FULL |=> trap_err && !upd_valid && tl == $past(tl));

  p_return_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req && (done_req || retry_req) && tl != '0 |=> tl == $past(tl) - TLW'(1));

  p_empty_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req && tl == '0 |=> !upd_valid && !trap_err && tl == '0);

  p_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_valid, trap_err}));

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tl <= TL_FULL);

endmodule

bind trap_state_stack tss_checker #(.MAXTL(MAXTL), .TLW(TLW), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .trap_req   (trap_req),
  .done_req   (done_req),
  .retry_req  (retry_req),
  .tl         (tl),
  .upd_valid  (upd_valid),
  .trap_err   (trap_err),
  .new_pc     (new_pc),
  .new_npc    (new_npc),
  .new_pstate (new_pstate)
);

// File: tb/trap_state_stack_tb_top.sv
`timescale 1ns/1ps
module trap_state_stack_tb_top;

  localparam int MAXTL = 5;
  localparam int AW    = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_req, done_req, retry_req;
  logic [8:0]  trap_type;
  logic [16:0] tba_hi;
  logic [31:0] cur_pc, cur_npc;
  logic [7:0]  cur_ccr, cur_asi;
  logic [11:0] cur_pstate;
  logic [2:0]  cur_cwp, cur_cansave;
  logic        upd_valid, trap_err;
  logic [31:0] new_pc, new_npc;
  logic [7:0]  new_ccr, new_asi;
  logic [11:0] new_pstate;
  logic [2:0]  new_cwp;
  logic [2:0]  tl;
  logic [8:0]  top_tt;
  logic [39:0] top_state;

  always #5 clk = ~clk;

  trap_state_stack #(.MAXTL(MAXTL), .NWIN(8), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .done_req(done_req), .retry_req(retry_req), .tba_hi(tba_hi),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
    .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
    .upd_valid(upd_valid), .new_pc(new_pc), .new_npc(new_npc),
    .new_ccr(new_ccr), .new_asi(new_asi), .new_pstate(new_pstate),
    .new_cwp(new_cwp), .trap_err(trap_err), .tl(tl), .top_tt(top_tt),
    .top_state(top_state)
  );

  typedef struct {
    bit          valid;
    bit          err;
    int          lvl;
    logic [31:0] pc, npc;
    logic [7:0]  ccr, asi;
    logic [11:0] pst;
    logic [2:0]  cwp;
    logic [8:0]  tt;
    logic [39:0] frame;
  } exp_t;

  exp_t  sb[$];
  string tag_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;

  // reference stack
  int          m_tl = 0;
  logic [39:0] m_word [MAXTL];
  logic [31:0] m_pc   [MAXTL];
  logic [31:0] m_npc  [MAXTL];
  logic [8:0]  m_tt   [MAXTL];

  task automatic set_cur(input logic [7:0] ccr, input logic [7:0] asi,
                         input logic [11:0] pst, input logic [2:0] cwp,
                         input logic [2:0] cs, input logic [31:0] pc);
    cur_ccr = ccr; cur_asi = asi; cur_pstate = pst; cur_cwp = cwp;
    cur_cansave = cs; cur_pc = pc; cur_npc = pc + 32'd4;
  endtask

  // driver: called at a falling edge, pushes the expectation for the next rising edge
  task automatic step(input string tag, input bit t, input bit d, input bit r,
                      input logic [8:0] ty);
    exp_t e;
    logic [39:0] w;
    trap_req = t; done_req = d; retry_req = r; trap_type = ty;
    e = '{default: '0};
    if (t) begin
      if (m_tl == MAXTL) begin
        e.err = 1'b1;
      end else begin
        m_word[m_tl] = {cur_ccr, cur_asi, 4'h0, cur_pstate & 12'hf3f, 5'b0, cur_cwp};
        m_pc[m_tl]   = cur_pc;
        m_npc[m_tl]  = cur_npc;
        m_tt[m_tl]   = ty;
        e.valid = 1'b1;
        e.pc    = {tba_hi, (m_tl > 1), ty, 5'b0};
        e.npc   = e.pc + 32'd4;
        e.ccr   = cur_ccr;
        e.asi   = cur_asi;
        e.pst   = (cur_pstate & 12'hf3f) | 12'h015 | ((m_tl >= MAXTL - 1) ? 12'h020 : 12'h000);
        if (ty == 9'h024)         e.cwp = cur_cwp - 3'd1;
        else if (ty[8:6] == 3'd2) e.cwp = cur_cwp - cur_cansave - 3'd2;
        else if (ty[8:6] == 3'd3) e.cwp = cur_cwp + 3'd1;
        else                      e.cwp = cur_cwp;
        m_tl++;
      end
    end else if ((d || r) && m_tl > 0) begin
      m_tl--;
      w = m_word[m_tl];
      e.valid = 1'b1;
      e.ccr = w[39:32]; e.asi = w[31:24]; e.pst = w[19:8]; e.cwp = w[2:0];
      if (d) begin e.pc = m_npc[m_tl]; e.npc = m_npc[m_tl] + 32'd4; end
      else   begin e.pc = m_pc[m_tl];  e.npc = m_npc[m_tl]; end
    end
    e.lvl   = m_tl;
    e.tt    = (m_tl == 0) ? 9'h0 : m_tt[m_tl-1];
    e.frame = (m_tl == 0) ? 40'h0 : m_word[m_tl-1];
    sb.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    trap_req = 0; done_req = 0; retry_req = 0;
  endtask

  // monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t  e;
        string tg;
        bit    bad;
        e  = sb.pop_front();
        tg = tag_q.pop_front();
        n_vec++;
        bad = (upd_valid !== e.valid) || (trap_err !== e.err) || (int'(tl) != e.lvl)
           || (top_tt !== e.tt) || (top_state !== e.frame);
        if (e.valid)
          bad = bad || (new_pc !== e.pc) || (new_npc !== e.npc) || (new_ccr !== e.ccr)
             || (new_asi !== e.asi) || (new_pstate !== e.pst) || (new_cwp !== e.cwp);
        if (bad) begin
          n_bad++;
          $display("FAIL %s: got v=%0b e=%0b tl=%0d pc=%h npc=%h ccr=%h asi=%h pst=%h cwp=%0d tt=%h st=%h | exp v=%0b e=%0b tl=%0d pc=%h npc=%h ccr=%h asi=%h pst=%h cwp=%0d tt=%h st=%h",
                   tg, upd_valid, trap_err, tl, new_pc, new_npc, new_ccr, new_asi,
                   new_pstate, new_cwp, top_tt, top_state,
                   e.valid, e.err, e.lvl, e.pc, e.npc, e.ccr, e.asi, e.pst, e.cwp,
                   e.tt, e.frame);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    trap_req = 0; done_req = 0; retry_req = 0; trap_type = '0;
    tba_hi = 17'h1_2345;
    set_cur(8'h00, 8'h00, 12'h000, 3'd0, 3'd0, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    n_vec++;
    if (tl !== 3'd0 || upd_valid !== 1'b0 || trap_err !== 1'b0
        || top_tt !== 9'h0 || top_state !== 40'h0) begin
      n_bad++;
      $display("FAIL R1: got tl=%0d v=%0b e=%0b tt=%h st=%h, expected all zero",
               tl, upd_valid, trap_err, top_tt, top_state);
    end

    set_cur(8'hA5, 8'h80, 12'h0C2, 3'd3, 3'd0, 32'h0000_1000);
    step("R10 done at level 0", 0, 1, 0, 9'h0);
    step("R2 R3 R4 trap 0x041", 1, 0, 0, 9'h041);
    set_cur(8'h3C, 8'h14, 12'h8D0, 3'd5, 3'd2, 32'h0000_2000);
    step("R9 spill trap", 1, 0, 0, 9'h085);
    set_cur(8'h77, 8'h19, 12'hFFF, 3'd0, 3'd1, 32'h0000_3000);
    step("R9 R4 clean-window wrap nested", 1, 0, 0, 9'h024);
    set_cur(8'h01, 8'h88, 12'h025, 3'd7, 3'd4, 32'h0000_4000);
    step("R9 fill wrap", 1, 0, 0, 9'h0C3);
    set_cur(8'hF0, 8'h0C, 12'h400, 3'd2, 3'd0, 32'h0000_5000);
    step("R5 trap at MAXTL-1", 1, 0, 0, 9'h100);
    set_cur(8'h99, 8'h99, 12'h999, 3'd1, 3'd1, 32'h0000_6000);
    step("R6 trap at MAXTL", 1, 0, 0, 9'h041);
    step("R10 R6 trap with done when full", 1, 1, 0, 9'h042);
    step("R8 retry", 0, 0, 1, 9'h0);
    step("R10 done beats retry", 0, 1, 1, 9'h0);
    set_cur(8'h5A, 8'hC3, 12'h13F, 3'd6, 3'd3, 32'h0000_7000);
    step("R10 trap beats done", 1, 1, 0, 9'h0A0);
    step("R7 done", 0, 1, 0, 9'h0);
    step("R8 retry", 0, 0, 1, 9'h0);
    step("R7 done", 0, 1, 0, 9'h0);
    step("R7 R11 done to level 0", 0, 1, 0, 9'h0);
    step("R10 retry at level 0", 0, 0, 1, 9'h0);
    step("R12 idle cycle", 0, 0, 0, 9'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule